// File: doc/BRIEF.md
# Multi-function GPIO port controller

A sixteen-pin general-purpose I/O port, set up by software through a 32-bit register window. Each pin has its own stored configuration: a direction/function mode, a push-pull or open-drain output type, a speed code, a pull setting and a four-bit alternate-function selector. From these the port drives the pad control lines: output enable, output value, open-drain flag, pull-up and pull-down. It also routes one of sixteen peripheral signals onto any pin placed in alternate-function mode.

Pad levels pass through a two-stage synchroniser and can then be read from an input register. Output levels are held in an output register. That register can be written as a whole, or updated bit by bit through a write-only set/clear register, so software never needs a read-modify-write sequence that an interrupt could break. Speed codes only change the exported speed bus.

The register port is a simple request bus. A request is presented with `bus_valid` and is always taken in the cycle it appears, so the bus has no back-pressure and no ready signal. A read returns its data one cycle later with `bus_rvalid` high for one cycle. A write returns nothing.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every configuration field, the output register and all pad enables are 0 (all pins in input mode), and every register reads 0.
- R2: Byte offsets: mode 0x00 (2 bits per pin at [2n+1:2n]), output type 0x04 (bit n; bits 31:16 read 0), speed 0x08 and pull 0x0C (2 bits per pin at [2n+1:2n]), alternate select 0x20 for pins 0-7 and 0x24 for pins 8-15 (4 bits at [4(n%8)+3:4(n%8)]). Each of these reads back what was written.
- R3: Input register at 0x10: bit n shows the pad level after two synchronising flops. A pad change made before clock edge E1 is returned by a read sampled at edge E3 but not by reads at E1 or E2. Writes to 0x10 have no effect.
- R4: A pin in analog mode (mode 3) reads 0 in the input register, whatever its pad level.
- R5: Set/clear register at 0x18: a 1 in bit n (0-15) sets output bit n, a 1 in bit n+16 clears it, and 0 bits leave it as it is. Set wins when both are 1. The register reads 0.
- R6: Output register at 0x14 can be written and read. In mode 1 a pin has pad_oe=1 and pad_out equal to its output bit.
- R7: In mode 2 pin n drives af_src[16n+sel], where sel is its alternate-select field, and pad_oe=1.
- R8: pad_od[n] follows output-type bit n. When it is 1, the pad is enabled only while the driven value is 0.
- R9: Pull code 1 raises pad_pu, 2 raises pad_pd, and 0 or the reserved 3 raise neither.
- R10: Input mode (0) and analog mode (3) keep pad_oe low.
- R11: A read gives bus_rdata with bus_rvalid high in the following cycle. A write gives no bus_rvalid. Offset 0x1C and any unmapped offset read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present; always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | 16 | Asynchronous pad levels |
| af_src | input | 256 | Peripheral signals, 16 per pin, pin n at [16n+15:16n] |
| pad_oe | output | 16 | Pad output enable |
| pad_out | output | 16 | Pad output value |
| pad_od | output | 16 | Open-drain select |
| pad_pu | output | 16 | Pull-up enable |
| pad_pd | output | 16 | Pull-down enable |
| pad_speed | output | 32 | Stored speed codes, 2 bits per pin |

## Verification
Two functions can act in the same cycle: the set and clear halves of the atomic register can both name one output bit in a single write. The tests send such a write, expect the bit to end up set, and confirm that untouched bits and all-zero writes leave the output register unchanged. A second overlap is between a pad change and a read of the input register. The tests change a pad and then issue back-to-back reads, expecting the old level on the first two reads and the new level only on the third.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    MODE_IN  = 2'd0,
    MODE_OUT = 2'd1,
    MODE_ALT = 2'd2,
    MODE_ANA = 2'd3
  } pin_mode_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_UP   = 2'd1,
    PULL_DOWN = 2'd2,
    PULL_RSVD = 2'd3
  } pin_pull_e;

  localparam logic [7:0] OFS_MODE  = 8'h00;
  localparam logic [7:0] OFS_OTYPE = 8'h04;
  localparam logic [7:0] OFS_SPEED = 8'h08;
  localparam logic [7:0] OFS_PULL  = 8'h0C;
  localparam logic [7:0] OFS_IN    = 8'h10;
  localparam logic [7:0] OFS_OUT   = 8'h14;
  localparam logic [7:0] OFS_SETCL = 8'h18;
  localparam logic [7:0] OFS_FREEZ = 8'h1C;
  localparam logic [7:0] OFS_ALTLO = 8'h20;
  localparam logic [7:0] OFS_ALTHI = 8'h24;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int SELW = 4,
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NPIN-1:0]      in_data,
  output logic [2*NPIN-1:0]    mode_o,
  output logic [NPIN-1:0]      otype_o,
  output logic [2*NPIN-1:0]    speed_o,
  output logic [2*NPIN-1:0]    pull_o,
  output logic [NPIN-1:0]      odr_o,
  output logic [SELW*NPIN-1:0] sel_o
);
  localparam int HALF  = NPIN / 2;
  localparam int HALFW = SELW * HALF;

  logic [2*NPIN-1:0] mode_q, speed_q, pull_q;
  logic [NPIN-1:0]   otype_q, odr_q;
  logic [HALFW-1:0]  sello_q, selhi_q;
  logic [DW-1:0]     rd_next;
  logic [NPIN-1:0]   set_bits, clr_bits;

  wire wr = bus_valid && bus_write;
  wire rd = bus_valid && !bus_write;

  assign set_bits = bus_wdata[NPIN-1:0];
  assign clr_bits = bus_wdata[NPIN +: NPIN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      otype_q <= '0;
      odr_q   <= '0;
      sello_q <= '0;
      selhi_q <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_MODE:  mode_q  <= bus_wdata[2*NPIN-1:0];
        OFS_OTYPE: otype_q <= bus_wdata[NPIN-1:0];
        OFS_SPEED: speed_q <= bus_wdata[2*NPIN-1:0];
        OFS_PULL:  pull_q  <= bus_wdata[2*NPIN-1:0];
        OFS_OUT:   odr_q   <= bus_wdata[NPIN-1:0];
        OFS_SETCL: odr_q   <= (odr_q & ~clr_bits) | set_bits;
        OFS_ALTLO: sello_q <= bus_wdata[HALFW-1:0];
        OFS_ALTHI: selhi_q <= bus_wdata[HALFW-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      OFS_MODE:  rd_next[2*NPIN-1:0] = mode_q;
      OFS_OTYPE: rd_next[NPIN-1:0]   = otype_q;
      OFS_SPEED: rd_next[2*NPIN-1:0] = speed_q;
      OFS_PULL:  rd_next[2*NPIN-1:0] = pull_q;
      OFS_IN:    rd_next[NPIN-1:0]   = in_data;
      OFS_OUT:   rd_next[NPIN-1:0]   = odr_q;
      OFS_ALTLO: rd_next[HALFW-1:0]  = sello_q;
      OFS_ALTHI: rd_next[HALFW-1:0]  = selhi_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_next;
    end
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign speed_o = speed_q;
  assign pull_o  = pull_q;
  assign odr_o   = odr_q;
  assign sel_o   = {selhi_q, sello_q};

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_SETCL) |=>
      ((odr_q & $past(set_bits)) == $past(set_bits)));

  // R11
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);

  // R11
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !bus_rvalid);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pad_in,
  input  logic [2*NPIN-1:0] mode,
  output logic [NPIN-1:0]   in_data
);
  logic [NPIN-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= pad_in;
      stage2_q <= stage1_q;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_mask
    assign in_data[i] = stage2_q[i] && (mode[2*i +: 2] != MODE_ANA);
  end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_port_pkg::*;
#(
  parameter int NAF  = 16,
  parameter int SELW = 4
) (
  input  logic [1:0]      mode,
  input  logic            otype,
  input  logic            odr,
  input  logic [1:0]      pull,
  input  logic [SELW-1:0] sel,
  input  logic [NAF-1:0]  af_src,
  output logic            oe,
  output logic            out,
  output logic            od,
  output logic            pu,
  output logic            pd
);
  logic value, drives;

  always_comb begin
    value  = 1'b0;
    drives = 1'b0;
    case (pin_mode_e'(mode))
      MODE_OUT: begin value = odr;         drives = 1'b1; end
      MODE_ALT: begin value = af_src[sel]; drives = 1'b1; end
      default:  begin value = 1'b0;        drives = 1'b0; end
    endcase
  end

  assign out = value;
  assign od  = otype;
  assign oe  = drives && (!otype || !value);
  assign pu  = (pin_pull_e'(pull) == PULL_UP);
  assign pd  = (pin_pull_e'(pull) == PULL_DOWN);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int NAF  = 16,
  parameter int DW   = 32,
  parameter int AW   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                bus_rvalid,
  input  logic [NPIN-1:0]     pad_in,
  input  logic [NPIN*NAF-1:0] af_src,
  output logic [NPIN-1:0]     pad_oe,
  output logic [NPIN-1:0]     pad_out,
  output logic [NPIN-1:0]     pad_od,
  output logic [NPIN-1:0]     pad_pu,
  output logic [NPIN-1:0]     pad_pd,
  output logic [2*NPIN-1:0]   pad_speed
);
  localparam int SELW = $clog2(NAF);

  logic [2*NPIN-1:0]    mode, pull;
  logic [NPIN-1:0]      otype, odr, in_data;
  logic [SELW*NPIN-1:0] sel;

  gpio_port_regs #(.NPIN(NPIN), .SELW(SELW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .in_data(in_data), .mode_o(mode), .otype_o(otype), .speed_o(pad_speed),
    .pull_o(pull), .odr_o(odr), .sel_o(sel)
  );

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .mode(mode), .in_data(in_data)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio_pin_drive #(.NAF(NAF), .SELW(SELW)) u_pin (
      .mode(mode[2*i +: 2]), .otype(otype[i]), .odr(odr[i]),
      .pull(pull[2*i +: 2]), .sel(sel[SELW*i +: SELW]),
      .af_src(af_src[NAF*i +: NAF]),
      .oe(pad_oe[i]), .out(pad_out[i]), .od(pad_od[i]),
      .pu(pad_pu[i]), .pd(pad_pd[i])
    );

    // R8
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_od[i] && pad_oe[i]) |-> !pad_out[i]);

    // R9
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pad_pu[i] && pad_pd[i]));

    // R10
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[2*i +: 2] == MODE_IN || mode[2*i +: 2] == MODE_ANA) |-> !pad_oe[i]);
  end
endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [15:0]  pad_in = '0;
  logic [255:0] af_src = '0;
  logic [15:0]  pad_oe, pad_out, pad_od, pad_pu, pad_pd;
  logic [31:0]  pad_speed;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .af_src(af_src),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_speed(pad_speed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    chk("R11 rvalid", {31'd0, bus_rvalid}, 32'd1);
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pad_oe", {16'd0, pad_oe}, 32'd0);
    rd(8'h00, d); chk("R1 mode", d, 32'd0);
    rd(8'h14, d); chk("R1 out", d, 32'd0);
    rd(8'h24, d); chk("R1 althi", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h00, 32'h5A5A_A5A5); rd(8'h00, d); chk("R2 mode", d, 32'h5A5A_A5A5);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R2 otype", d, 32'h0000_FFFF);
    wr(8'h08, 32'h1234_5678); rd(8'h08, d); chk("R2 speed", d, 32'h1234_5678);
    chk("R2 speed bus", pad_speed, 32'h1234_5678);
    wr(8'h20, 32'hCAFE_0123); rd(8'h20, d); chk("R2 altlo", d, 32'hCAFE_0123);
    wr(8'h24, 32'h8765_4321); rd(8'h24, d); chk("R2 althi", d, 32'h8765_4321);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0); wr(8'h20, 32'h0); wr(8'h24, 32'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(8'h14, 32'h0000_00F0);
    wr(8'h18, 32'h0001_0002); rd(8'h14, d); chk("R5 set", d, 32'h0000_00F2);
    wr(8'h18, 32'h0010_0000); rd(8'h14, d); chk("R5 clear", d, 32'h0000_00E2);
    wr(8'h18, 32'h0100_0100); rd(8'h14, d); chk("R5 set wins", d, 32'h0000_01E2);
    wr(8'h18, 32'h0); rd(8'h14, d); chk("R5 zero write", d, 32'h0000_01E2);
    rd(8'h18, d); chk("R5 reads zero", d, 32'h0);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_output();
    wr(8'h00, 32'h0000_0040);
    wr(8'h14, 32'h0000_0008);
    chk("R6 oe", {16'd0, pad_oe}, 32'h0000_0008);
    chk("R6 out high", {31'd0, pad_out[3]}, 32'd1);
    wr(8'h18, 32'h0008_0000);
    chk("R6 out low", {31'd0, pad_out[3]}, 32'd0);
    wr(8'h00, 32'h0);
    chk("R10 input oe", {16'd0, pad_oe}, 32'd0);
  endtask

  task automatic t_alt();
    wr(8'h00, 32'h0020_0020);
    wr(8'h20, 32'h0000_0500);
    wr(8'h24, 32'h0000_0C00);
    af_src[37] = 1'b1; #1;
    chk("R7 pin2 sel5 high", {30'd0, pad_oe[2], pad_out[2]}, 32'd3);
    af_src[37] = 1'b0; af_src[36] = 1'b1; #1;
    chk("R7 pin2 other src", {31'd0, pad_out[2]}, 32'd0);
    af_src[172] = 1'b1; #1;
    chk("R7 pin10 hi sel", {30'd0, pad_oe[10], pad_out[10]}, 32'd3);
    af_src = '0;
    wr(8'h00, 32'h0); wr(8'h20, 32'h0); wr(8'h24, 32'h0);
  endtask

  task automatic t_opendrain();
    wr(8'h00, 32'h0000_0040);
    wr(8'h04, 32'h0000_0008);
    wr(8'h14, 32'h0000_0008);
    chk("R8 od flag", {31'd0, pad_od[3]}, 32'd1);
    chk("R8 release", {31'd0, pad_oe[3]}, 32'd0);
    wr(8'h14, 32'h0);
    chk("R8 pull low", {30'd0, pad_oe[3], pad_out[3]}, 32'd2);
    wr(8'h00, 32'h0); wr(8'h04, 32'h0);
  endtask

  task automatic t_pull();
    logic [31:0] d;
    wr(8'h0C, 32'h0000_0039);
    chk("R9 pu", {16'd0, pad_pu}, 32'h1);
    chk("R9 pd", {16'd0, pad_pd}, 32'h2);
    rd(8'h0C, d); chk("R2 pull", d, 32'h39);
    wr(8'h0C, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    pad_in = 16'hBEEF;
    rd(8'h10, d); chk("R3 edge1 old", d, 32'h0);
    rd(8'h10, d); chk("R3 edge2 old", d, 32'h0);
    rd(8'h10, d); chk("R3 edge3 new", d, 32'h0000_BEEF);
    wr(8'h10, 32'h0); rd(8'h10, d); chk("R3 write ignored", d, 32'h0000_BEEF);
    wr(8'h00, 32'h0000_0003);
    rd(8'h10, d); chk("R4 analog zero", d, 32'h0000_BEEE);
    chk("R10 analog oe", {16'd0, pad_oe}, 32'd0);
    wr(8'h00, 32'h0);
    pad_in = '0;
  endtask

  task automatic t_misc();
    logic [31:0] d;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h1C; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R11 no rvalid on write", {31'd0, bus_rvalid}, 32'd0);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd(8'h1C, d); chk("R11 freeze offset", d, 32'h0);
    wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C, d); chk("R11 unmapped", d, 32'h0);
    rd(8'h00, d); chk("R11 no side effect", d, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_setclr();
    t_output();
    t_alt();
    t_opendrain();
    t_pull();
    t_input();
    t_misc();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule